// File: doc/BRIEF.md
# Pipelined Bus Arbiter with Acknowledge Timeout

This block arbitrates a processor-side bus whose address path is separate from its read-data and write-data paths. Several masters each present a request made of a request priority, a direction flag (read or write), a lock flag and an address. When the address path is free, the arbiter selects one eligible master and drives its address phase towards the slaves. It holds that phase until one of four things ends it: a slave acknowledges it, a slave forces rearbitration, the owning master aborts it, or the acknowledge window runs out.

Acknowledged phases are counted as occupancy of a read pipeline and a write pipeline. This lets new address phases overlap data transfers that are still in progress. A direction whose pipeline is full is not granted. Each data path reports a finished transfer on its own input, and both may report in the same cycle.

A master that holds its lock flag after an acknowledged phase keeps exclusive access to the address path until it lowers the flag.

Top module: `pipe_bus_arbiter`

## Requirements
- R1: Among eligible requests, the one with the numerically highest request priority (`req_prio`, 2 bits per master, master m in bits [2m+1:2m]) wins.
- R2: When request priorities are equal, the higher fixed device priority wins. By default masters 0 and 1 have device priority 1 and masters 2 and 3 have device priority 0.
- R3: When both priorities are equal, the grant rotates. The search starts at the master after the most recent winner and wraps around.
- R4: `rd_occ` rises by one for each acknowledged read phase and falls by one on each `rd_xfer_end` pulse. No read is granted while `rd_occ` is 4, which is one transfer in progress plus three pending.
- R5: `wr_occ` rises by one for each acknowledged write phase and falls by one on each `wr_xfer_end` pulse. No write is granted while `wr_occ` is 2. A blocked write does not stop an eligible read from being granted.
- R6: An address phase that receives no acknowledge, abort or rearbitration ends with `done_status` TIMEOUT (1) in its 16th cycle. `addr_valid` is low in the following cycle.
- R7: After a master's acknowledged phase with `req_lock` high, only that master can be granted until it lowers `req_lock`, even if others request with higher priority.
- R8: `sl_rearb` during an address phase ends it with status REARB (3). The request stays pending and competes again.
- R9: `req_abort` from the owning master during its address phase ends it with status ABORT (2). The phase is released and no pipeline occupancy is added.
- R10: `rd_xfer_end` and `wr_xfer_end` in the same cycle lower both occupancy counts in that cycle.
- R11: While reset is asserted, `gnt`, `addr_valid` and `done_valid` are 0 and both occupancy counts are 0.
- R12: A grant appears one cycle after the arbiter is idle with an eligible request. `gnt` is one-hot on the owner, `addr_out` carries the owner's address and stays stable through the phase, and `sl_addr_ack` ends the phase with status OK (0) in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 4 | Request pending, one bit per master |
| req_prio | input | 8 | Request priority, 2 bits per master |
| req_rnw | input | 4 | 1 = read, 0 = write, per master |
| req_lock | input | 4 | Lock request, per master |
| req_abort | input | 4 | Abort own address phase, per master |
| req_addr | input | 128 | Address, 32 bits per master |
| sl_addr_ack | input | 1 | Slave acknowledges the current address phase |
| sl_rearb | input | 1 | Slave forces rearbitration |
| rd_xfer_end | input | 1 | One read data transfer finished |
| wr_xfer_end | input | 1 | One write data transfer finished |
| gnt | output | 4 | One-hot owner of the address phase |
| addr_valid | output | 1 | Address phase active |
| addr_out | output | 32 | Address of the active phase |
| addr_rnw | output | 1 | Direction of the active phase |
| addr_master | output | 2 | Index of the owner |
| done_valid | output | 1 | Address phase ends this cycle |
| done_status | output | 2 | 0 OK, 1 TIMEOUT, 2 ABORT, 3 REARB |
| done_master | output | 2 | Master whose phase ends |
| rd_occ | output | 3 | Read pipeline occupancy |
| wr_occ | output | 3 | Write pipeline occupancy |

## Verification
A wrong occupancy count appears at the ports within a cycle of the acknowledge or transfer-end event that caused it. It then shows a second time as a grant withheld or given in the wrong direction at the next arbitration. A stale lock or a wrong rotation pointer shows only at the next contested grant, so the stimulus offers competing requests right after each such event. A timer that is off by one moves the TIMEOUT completion by one cycle, and the bench counts those cycles exactly.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_TIMEOUT = 2'd1,
        ST_ABORT   = 2'd2,
        ST_REARB   = 2'd3
    } done_st_e;
endpackage

// File: rtl/arb_winner_sel.sv
module arb_winner_sel #(
    parameter int NM  = 4,
    parameter int PW  = 2,
    parameter int DPW = 2,
    parameter logic [NM*DPW-1:0] DEV_PRIO = '0,
    parameter int IW  = 2
) (
    input  logic [NM-1:0]    elig,
    input  logic [NM*PW-1:0] prio,
    input  logic [IW-1:0]    rr_start,
    output logic             found,
    output logic [IW-1:0]    win_idx
);
    localparam int KW = PW + DPW;

    logic [KW-1:0] key [NM];
    logic [KW-1:0] best;
    logic          any;

    // Combined key: request priority above device priority
    for (genvar g = 0; g < NM; g++) begin : g_key
        assign key[g] = {prio[g*PW +: PW], DEV_PRIO[g*DPW +: DPW]};
    end

    always_comb begin
        best = '0;
        any  = 1'b0;
        for (int m = 0; m < NM; m++) begin
            if (elig[m] && (!any || key[m] > best)) begin
                best = key[m];
                any  = 1'b1;
            end
        end
    end

    // Rotating search among the top-key candidates
    always_comb begin
        int j;
        found   = 1'b0;
        win_idx = '0;
        for (int k = 0; k < NM; k++) begin
            j = int'(rr_start) + k;
            if (j >= NM) j = j - NM;
            if (!found && elig[j] && key[j] == best) begin
                found   = 1'b1;
                win_idx = IW'(j);
            end
        end
    end
endmodule

// File: rtl/arb_pipe_occ.sv
module arb_pipe_occ #(
    parameter int CAP = 4,
    parameter int CW  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          room
);
    logic [CW-1:0] cnt_d, cnt_q;
    logic          dec_eff;

    always_comb begin
        dec_eff = dec && (cnt_q != '0);
        cnt_d   = cnt_q + CW'(inc) - CW'(dec_eff);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt  = cnt_q;
    assign room = (cnt_q < CW'(CAP));
endmodule

// File: rtl/arb_ack_timer.sv
module arb_ack_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!active)                     cnt_d = '0;
        else if (cnt_q == TW'(LIMIT - 1)) cnt_d = cnt_q;
        else                             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = active && (cnt_q == TW'(LIMIT - 1));
endmodule

// File: rtl/pipe_bus_arbiter.sv
module pipe_bus_arbiter #(
    parameter int NUM_MASTERS = 4,
    parameter int PRIO_W      = 2,
    parameter int DEV_W       = 2,
    parameter logic [NUM_MASTERS*DEV_W-1:0] DEV_PRIO = 8'h05,
    parameter int ADDR_W      = 32,
    parameter int RD_PEND     = 3,
    parameter int WR_PEND     = 1,
    parameter int ACK_TIMEOUT = 16,
    localparam int IDX_W      = $clog2(NUM_MASTERS),
    localparam int RD_CAP     = RD_PEND + 1,
    localparam int WR_CAP     = WR_PEND + 1,
    localparam int OCC_W      = $clog2(((RD_CAP > WR_CAP) ? RD_CAP : WR_CAP) + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_MASTERS-1:0]        req_valid,
    input  logic [NUM_MASTERS*PRIO_W-1:0] req_prio,
    input  logic [NUM_MASTERS-1:0]        req_rnw,
    input  logic [NUM_MASTERS-1:0]        req_lock,
    input  logic [NUM_MASTERS-1:0]        req_abort,
    input  logic [NUM_MASTERS*ADDR_W-1:0] req_addr,
    input  logic                          sl_addr_ack,
    input  logic                          sl_rearb,
    input  logic                          rd_xfer_end,
    input  logic                          wr_xfer_end,
    output logic [NUM_MASTERS-1:0]        gnt,
    output logic                          addr_valid,
    output logic [ADDR_W-1:0]             addr_out,
    output logic                          addr_rnw,
    output logic [IDX_W-1:0]              addr_master,
    output logic                          done_valid,
    output logic [1:0]                    done_status,
    output logic [IDX_W-1:0]              done_master,
    output logic [OCC_W-1:0]              rd_occ,
    output logic [OCC_W-1:0]              wr_occ
);
    import arb_pkg::*;

    typedef struct packed {
        logic              busy;
        logic [IDX_W-1:0]  owner;
        logic [ADDR_W-1:0] addr;
        logic              rnw;
        logic              lock_v;
        logic [IDX_W-1:0]  lock_m;
        logic [IDX_W-1:0]  rr;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic [NUM_MASTERS-1:0] elig;
    logic                   pick_found;
    logic [IDX_W-1:0]       pick_idx;
    logic                   rd_room, wr_room;
    logic                   tmr_expired;
    logic                   lock_hold;
    logic                   ev_abort, ev_ack, ev_rearb, ev_to;
    done_st_e               status;

    // Eligibility: pipeline room for the direction, lock restriction
    always_comb begin
        lock_hold = st_q.lock_v && req_lock[st_q.lock_m];
        for (int m = 0; m < NUM_MASTERS; m++) begin
            elig[m] = req_valid[m]
                   && (req_rnw[m] ? rd_room : wr_room)
                   && (!lock_hold || st_q.lock_m == IDX_W'(m));
        end
    end

    arb_winner_sel #(
        .NM(NUM_MASTERS), .PW(PRIO_W), .DPW(DEV_W),
        .DEV_PRIO(DEV_PRIO), .IW(IDX_W)
    ) u_sel (
        .elig(elig), .prio(req_prio), .rr_start(st_q.rr),
        .found(pick_found), .win_idx(pick_idx)
    );

    arb_ack_timer #(.LIMIT(ACK_TIMEOUT)) u_tmr (
        .clk(clk), .rst_n(rst_n), .active(st_q.busy), .expired(tmr_expired)
    );

    // Address-phase ending events in fixed precedence
    always_comb begin
        ev_abort = st_q.busy && req_abort[st_q.owner];
        ev_ack   = st_q.busy && !ev_abort && sl_addr_ack;
        ev_rearb = st_q.busy && !ev_abort && !ev_ack && sl_rearb;
        ev_to    = st_q.busy && !ev_abort && !ev_ack && !ev_rearb && tmr_expired;
        if (ev_abort)      status = ST_ABORT;
        else if (ev_rearb) status = ST_REARB;
        else if (ev_to)    status = ST_TIMEOUT;
        else               status = ST_OK;
    end

    arb_pipe_occ #(.CAP(RD_CAP), .CW(OCC_W)) u_rd_occ (
        .clk(clk), .rst_n(rst_n),
        .inc(ev_ack && st_q.rnw), .dec(rd_xfer_end),
        .cnt(rd_occ), .room(rd_room)
    );

    arb_pipe_occ #(.CAP(WR_CAP), .CW(OCC_W)) u_wr_occ (
        .clk(clk), .rst_n(rst_n),
        .inc(ev_ack && !st_q.rnw), .dec(wr_xfer_end),
        .cnt(wr_occ), .room(wr_room)
    );

    // Next-state
    always_comb begin
        st_d = st_q;

        if (st_q.lock_v && !req_lock[st_q.lock_m]) st_d.lock_v = 1'b0;

        if (ev_abort || ev_ack || ev_rearb || ev_to) st_d.busy = 1'b0;

        if (ev_ack && req_lock[st_q.owner]) begin
            st_d.lock_v = 1'b1;
            st_d.lock_m = st_q.owner;
        end

        if (!st_q.busy && pick_found) begin
            st_d.busy  = 1'b1;
            st_d.owner = pick_idx;
            st_d.addr  = req_addr[pick_idx*ADDR_W +: ADDR_W];
            st_d.rnw   = req_rnw[pick_idx];
            st_d.rr    = (pick_idx == IDX_W'(NUM_MASTERS - 1)) ? '0 : pick_idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_gnt
        assign gnt[g] = st_q.busy && (st_q.owner == IDX_W'(g));
    end

    assign addr_valid  = st_q.busy;
    assign addr_out    = st_q.addr;
    assign addr_rnw    = st_q.rnw;
    assign addr_master = st_q.owner;
    assign done_valid  = ev_abort || ev_ack || ev_rearb || ev_to;
    assign done_status = status;
    assign done_master = st_q.owner;
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
    parameter int NM      = 4,
    parameter int AW      = 32,
    parameter int OCC_W   = 3,
    parameter int RD_CAP  = 4,
    parameter int WR_CAP  = 2,
    parameter int TIMEOUT = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NM-1:0]    gnt,
    input logic             addr_valid,
    input logic [AW-1:0]    addr_out,
    input logic             addr_rnw,
    input logic             done_valid,
    input logic [1:0]       done_status,
    input logic [OCC_W-1:0] rd_occ,
    input logic [OCC_W-1:0] wr_occ,
    input logic             rd_xfer_end
);
    localparam int CW = $clog2(TIMEOUT + 1) + 1;

    logic [CW-1:0] phase_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         phase_cnt <= '0;
        else if (addr_valid && !done_valid) phase_cnt <= phase_cnt + 1'b1;
        else                                phase_cnt <= '0;
    end

    p_gnt_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    p_addr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && !done_valid |=> addr_valid && $stable(addr_out) && $stable(gnt));

    p_gap_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !addr_valid);

    p_rd_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_occ <= OCC_W'(RD_CAP));

    p_wr_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_occ <= OCC_W'(WR_CAP));

    p_ack_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> phase_cnt < CW'(TIMEOUT));

    p_timeout_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && done_status == 2'd1 |-> phase_cnt == CW'(TIMEOUT - 1));

    p_rd_grow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && done_status == 2'd0 && addr_rnw && !rd_xfer_end
        |=> rd_occ == OCC_W'($past(rd_occ) + 1'b1));
endmodule

bind pipe_bus_arbiter arb_chk #(
    .NM(NUM_MASTERS), .AW(ADDR_W), .OCC_W(OCC_W),
    .RD_CAP(RD_CAP), .WR_CAP(WR_CAP), .TIMEOUT(ACK_TIMEOUT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .gnt(gnt), .addr_valid(addr_valid),
    .addr_out(addr_out), .addr_rnw(addr_rnw), .done_valid(done_valid),
    .done_status(done_status), .rd_occ(rd_occ), .wr_occ(wr_occ),
    .rd_xfer_end(rd_xfer_end)
);

// File: tb/pipe_bus_arbiter_tb.sv
module pipe_bus_arbiter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NM = 4;
    localparam int PW = 2;
    localparam int AW = 32;
    localparam int A_ACK = 0, A_TO = 1, A_ABORT = 2, A_REARB = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NM-1:0]    req_valid = '0, req_rnw = '0, req_lock = '0, req_abort = '0;
    logic [NM*PW-1:0] req_prio = '0;
    logic [NM*AW-1:0] req_addr = '0;
    logic sl_addr_ack = 1'b0, sl_rearb = 1'b0, rd_xfer_end = 1'b0, wr_xfer_end = 1'b0;
    logic [NM-1:0] gnt;
    logic          addr_valid, addr_rnw, done_valid;
    logic [AW-1:0] addr_out;
    logic [1:0]    addr_master, done_master, done_status;
    logic [2:0]    rd_occ, wr_occ;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pipe_bus_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_prio(req_prio),
        .req_rnw(req_rnw), .req_lock(req_lock), .req_abort(req_abort),
        .req_addr(req_addr), .sl_addr_ack(sl_addr_ack), .sl_rearb(sl_rearb),
        .rd_xfer_end(rd_xfer_end), .wr_xfer_end(wr_xfer_end), .gnt(gnt),
        .addr_valid(addr_valid), .addr_out(addr_out), .addr_rnw(addr_rnw),
        .addr_master(addr_master), .done_valid(done_valid),
        .done_status(done_status), .done_master(done_master),
        .rd_occ(rd_occ), .wr_occ(wr_occ)
    );

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", rq, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic set_req(input int m, input bit v, input int p, input bit rnw,
                           input bit lk, input logic [AW-1:0] a);
        req_valid[m]         = v;
        req_prio[m*PW +: PW] = PW'(p);
        req_rnw[m]           = rnw;
        req_lock[m]          = lk;
        req_addr[m*AW +: AW] = a;
    endtask

    task automatic pulse(input bit r, input bit w);
        step();
        rd_xfer_end = r;
        wr_xfer_end = w;
        step();
        rd_xfer_end = 1'b0;
        wr_xfer_end = 1'b0;
    endtask

    // Driver: waits for the grant, pushes the expected completion, applies the action
    task automatic serve(input int m, input int act, input string tag, input logic [AW-1:0] ea);
        bit seen = 1'b0;
        int n;
        for (int i = 0; i < 40 && !seen; i++) begin
            @(negedge clk);
            if (addr_valid) seen = 1'b1;
        end
        chk(seen && gnt == NM'(1 << m), tag, gnt, 1 << m);
        chk(addr_out == ea, "R12 addr", addr_out, ea);
        exp_q.push_back(m*4 + act);
        tag_q.push_back(tag);
        step();
        case (act)
            A_ACK:   begin sl_addr_ack = 1'b1; step(); sl_addr_ack = 1'b0; end
            A_ABORT: begin req_abort[m] = 1'b1; step(); req_abort[m] = 1'b0; end
            A_REARB: begin sl_rearb = 1'b1; step(); sl_rearb = 1'b0; end
            default: begin
                n = 1;
                for (int i = 0; i < 40; i++) begin
                    @(negedge clk);
                    n++;
                    if (done_valid) break;
                end
                chk(n == 16, "R6 timeout cycle", n, 16);
                step();
            end
        endcase
    endtask

    // Monitor: pops the scoreboard on every completion
    always @(negedge clk) begin
        if (rst_n && done_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R12 unexpected completion", done_master*4 + done_status, -1);
            end else begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(done_master == 2'(e/4) && done_status == 2'(e%4), t,
                    done_master*4 + done_status, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R11 reset state
        repeat (3) @(negedge clk);
        chk(gnt == '0 && !addr_valid && !done_valid, "R11 outputs idle", gnt, 0);
        chk(rd_occ == 0 && wr_occ == 0, "R11 occupancy", rd_occ + wr_occ, 0);
        step();
        rst_n = 1'b1;

        // R1: higher request priority first, then the remaining master
        set_req(0, 1, 1, 1, 0, 32'h0000_1000);
        set_req(3, 1, 3, 1, 0, 32'h0000_3000);
        serve(3, A_ACK, "R1 prio winner", 32'h0000_3000);
        set_req(3, 0, 0, 0, 0, 0);
        serve(0, A_ACK, "R12 ok status", 32'h0000_1000);
        set_req(0, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk(rd_occ == 2, "R4 read count", rd_occ, 2);

        // R2: equal request priority, device priority decides
        step();
        set_req(1, 1, 2, 0, 0, 32'h0000_1100);
        set_req(2, 1, 2, 0, 0, 32'h0000_2200);
        serve(1, A_ACK, "R2 device prio", 32'h0000_1100);
        set_req(1, 0, 0, 0, 0, 0);
        serve(2, A_ACK, "R2 second", 32'h0000_2200);
        set_req(2, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk(wr_occ == 2, "R5 write count full", wr_occ, 2);

        // R5: full write pipe blocks a write, a read still goes
        step();
        set_req(0, 1, 3, 0, 0, 32'h0000_0A00);
        set_req(2, 1, 0, 1, 0, 32'h0000_0B00);
        serve(2, A_ACK, "R5 read passes blocked write", 32'h0000_0B00);
        set_req(2, 0, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!addr_valid, "R5 write withheld", addr_valid, 0);
        end
        // R10: both transfer ends in one cycle
        pulse(1, 1);
        @(negedge clk);
        chk(rd_occ == 2 && wr_occ == 1, "R10 dual end", rd_occ*8 + wr_occ, 2*8 + 1);
        serve(0, A_ACK, "R5 write after room", 32'h0000_0A00);
        set_req(0, 0, 0, 0, 0, 0);
        pulse(0, 1);
        pulse(0, 1);
        @(negedge clk);
        chk(wr_occ == 0, "R5 write drained", wr_occ, 0);

        // R4: read pipe fills to four and blocks
        step();
        set_req(1, 1, 0, 1, 0, 32'h0000_4100);
        serve(1, A_ACK, "R4 read three", 32'h0000_4100);
        set_req(1, 0, 0, 0, 0, 0);
        set_req(2, 1, 0, 1, 0, 32'h0000_4200);
        serve(2, A_ACK, "R4 read four", 32'h0000_4200);
        set_req(2, 0, 0, 0, 0, 0);
        set_req(3, 1, 0, 1, 0, 32'h0000_4300);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!addr_valid && rd_occ == 4, "R4 read withheld", rd_occ, 4);
        end
        pulse(1, 0);

        // R9: abort releases the phase and adds nothing
        serve(3, A_ABORT, "R9 abort", 32'h0000_4300);
        set_req(3, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk(!addr_valid && rd_occ == 3, "R9 released", rd_occ, 3);

        // R6: timeout
        step();
        set_req(1, 1, 0, 1, 0, 32'h0000_6100);
        serve(1, A_TO, "R6 timeout status", 32'h0000_6100);
        set_req(1, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk(!addr_valid && rd_occ == 3, "R6 free after timeout", addr_valid, 0);

        // R8: rearbitration returns the request to competition
        step();
        set_req(2, 1, 1, 0, 0, 32'h0000_8200);
        serve(2, A_REARB, "R8 rearb status", 32'h0000_8200);
        serve(2, A_ACK, "R8 regrant", 32'h0000_8200);
        set_req(2, 0, 0, 0, 0, 0);

        // R3: rotation among fully tied masters (last winner was 2)
        set_req(0, 1, 0, 0, 0, 32'h0000_3000);
        set_req(1, 1, 0, 0, 0, 32'h0000_3100);
        serve(0, A_ABORT, "R3 rotate first", 32'h0000_3000);
        serve(1, A_ABORT, "R3 rotate second", 32'h0000_3100);
        serve(0, A_ABORT, "R3 rotate wrap", 32'h0000_3000);
        set_req(0, 0, 0, 0, 0, 0);
        set_req(1, 0, 0, 0, 0, 0);

        // R7: lock keeps ownership against a higher priority request
        pulse(0, 1);
        set_req(3, 1, 0, 0, 1, 32'h0000_7300);
        serve(3, A_ACK, "R7 locked first", 32'h0000_7300);
        set_req(3, 1, 0, 0, 1, 32'h0000_7304);
        set_req(0, 1, 3, 1, 0, 32'h0000_7000);
        serve(3, A_ACK, "R7 lock holds", 32'h0000_7304);
        set_req(3, 0, 0, 0, 0, 0);
        serve(0, A_ABORT, "R7 after unlock", 32'h0000_7000);
        set_req(0, 0, 0, 0, 0, 0);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R12 all completions seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule